// File: doc/BRIEF.md
# DRAM Initialization Trigger and Lock Controller

This block is the register-facing control front of a DDR2 memory controller. It holds the configuration, timing and refresh-rate registers and enforces the two unlock protocols that guard them. The drive-strength field can only change through a boot-unlock handshake. The timing registers and the CAS-latency field can only change while the timing-unlock bit is set.

The block decides when the attached DRAM devices must be initialized. This happens after a hard reset, after a soft reset, or after a software write that enables either of the two low byte lanes of the configuration register. It first waits until the command queue reports idle, so that queued reads and writes are never lost. It then issues a fixed nine-step mode-register programming sequence on an abstract command port. The block advances one step each time a command-done pulse arrives. It builds the mode and extended-mode-1 words from the live configuration.

While a sequence is pending or running, `busy_o` is high, and the surrounding controller uses it to stop accepting new requests. A trigger that arrives during a sequence is remembered, and it causes exactly one more sequence afterwards.

Top module: `dram_init_ctrl`

## Requirements
- R1: When the asynchronous hard reset `rst_ni` is asserted, the registers load their defaults: configuration reads 0x0000_0205 (CAS latency 5, rows 2), timing 1 reads 0x2222_1111, timing 2 reads 0x0000_3333 and refresh reads 0x0000_0618. `busy_o` is high after reset is released, and an initialization sequence then runs.
- R2: A one-cycle pulse on `soft_rst_i` leaves every register unchanged. It sets `busy_o` and starts a sequence that uses the previously programmed values.
- R3: A write to address 0 with `reg_be_i[0]` or `reg_be_i[1]` set starts a sequence, and `busy_o` is high from the next cycle. A write to address 0 that enables only bytes 2 and 3 starts none.
- R4: After a trigger, no command is issued until `cmdq_idle_i` has been sampled high. While it stays low, `cmd_valid_o` stays low and `busy_o` stays high.
- R5: The configuration register has drive strength in bit 3 and boot-unlock in bit 4 is not used; boot-unlock is bit 5. A byte-0 write with bit 5 set sets boot-unlock and leaves drive unchanged. A byte-0 write with bit 5 clear, made while boot-unlock is set, loads drive from bit 3 and clears boot-unlock. Any other write leaves drive unchanged.
- R6: Timing-unlock is configuration bit 4. The timing registers (addresses 1 and 2, with byte-lane merge) and the CAS-latency field (configuration bits 2:0) accept a write only when timing-unlock was already set before that write. A write of bit 4 as 0 locks them again.
- R7: The sequence uses the opcodes PRE=1, REF=2 and MRS=3. With the bank select on `cmd_bank_o`, it runs in this order: PRE (address 0x0400), MRS bank 2 (0), MRS bank 3 (0), MRS bank 1 (EMR1), MRS bank 0 (MR with bit 8 set), PRE (0x0400), REF, REF, MRS bank 0 (MR). A command is held until `cmd_done_i` is seen, and each done pulse advances one step.
- R8: EMR1 has bit 0 = 0, bit 1 = drive, bit 2 = 1 and bit 6 = 0, and all other bits are 0. MR carries the CAS latency in bits 6:4, and all other bits are 0 except the DLL-reset bit 8 in step 4.
- R9: `busy_o` stays high until the done of the last command. A trigger that arrives while busy keeps `busy_o` high after that done, and it runs exactly one more full sequence.
- R10: The refresh register (address 3, bits 15:0) accepts a write at any time except while `busy_o` is high, when the write is ignored.
- R11: `irq_o` and `dma_evt_o` are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Hard reset, asynchronous, active low |
| soft_rst_i | input | 1 | Soft reset pulse, synchronous |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Word address: 0 config, 1 timing 1, 2 timing 2, 3 refresh |
| reg_be_i | input | 4 | Byte enables |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| cmdq_idle_i | input | 1 | Command queue holds no pending access |
| cmd_valid_o | output | 1 | DRAM command valid |
| cmd_op_o | output | 2 | Opcode: 1 PRE, 2 REF, 3 MRS |
| cmd_bank_o | output | 2 | Mode register select for MRS |
| cmd_addr_o | output | 16 | Address/mode word |
| cmd_done_i | input | 1 | Command completed |
| busy_o | output | 1 | Init pending or running; request acceptance blocked |
| irq_o | output | 1 | Interrupt, tied low |
| dma_evt_o | output | 1 | DMA event request, tied low |

## Verification
The register path is driven by a vector table of writes that cover each lock state:
- timing writes with the lock closed and then open,
- CAS-latency writes made in the same write that opens the lock and in the same write that closes it,
- the full boot-unlock handshake, and a drive write without that handshake,
- upper-lane-only writes that must not trigger.

Each triggering vector is followed by a full sequence check. That check tells a stale configuration apart from a fresh one through the EMR1 and MR words.

Directed cases cover four behaviours:
- holding the queue busy, which separates deferred start from immediate start;
- a retrigger in the middle of a sequence, which separates latching from dropping;
- a refresh write while busy;
- soft reset and then hard reset, which separates keeping the registers from reloading them.

// File: rtl/dic_pkg.sv
package dic_pkg;
  typedef enum logic [1:0] {
    OP_NOP = 2'd0,
    OP_PRE = 2'd1,
    OP_REF = 2'd2,
    OP_MRS = 2'd3
  } dram_op_e;

  typedef struct packed {
    logic [7:0] misc;
    logic [2:0] rows;
    logic       boot_unlock;
    logic       tim_unlock;
    logic       drive;
    logic [2:0] cl;
  } cfg_t;

  localparam int unsigned NSTEPS = 9;
endpackage

// File: rtl/dic_regs.sv
module dic_regs
  import dic_pkg::*;
#(
  parameter int unsigned DW       = 32,
  parameter int unsigned AW       = 2,
  parameter int unsigned RFR_W    = 16,
  parameter logic [2:0]  CL_RST   = 3'd5,
  parameter logic [2:0]  ROWS_RST = 3'd2,
  parameter logic [DW-1:0] TIM1_RST = 32'h2222_1111,
  parameter logic [DW-1:0] TIM2_RST = 32'h0000_3333,
  parameter logic [RFR_W-1:0] RFR_RST = 16'h0618
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW/8-1:0]   be_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              busy_i,
  output cfg_t              cfg_o,
  output logic [DW-1:0]     tim1_o,
  output logic [DW-1:0]     tim2_o,
  output logic [RFR_W-1:0]  rfr_o,
  output logic [DW-1:0]     rdata_o,
  output logic              cfg_lo_wr_o
);
  localparam int unsigned NB   = DW / 8;
  localparam int unsigned RFRB = RFR_W / 8;

  cfg_t              cfg_q;
  logic [DW-1:0]     tim1_q, tim2_q;
  logic [RFR_W-1:0]  rfr_q;

  logic wr_cfg, wr_t1, wr_t2, wr_rf;
  assign wr_cfg = we_i && (addr_i == AW'(0));
  assign wr_t1  = we_i && (addr_i == AW'(1));
  assign wr_t2  = we_i && (addr_i == AW'(2));
  assign wr_rf  = we_i && (addr_i == AW'(3));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '{misc: 8'h00, rows: ROWS_RST, boot_unlock: 1'b0,
                 tim_unlock: 1'b0, drive: 1'b0, cl: CL_RST};
    end else if (wr_cfg) begin
      if (be_i[0]) begin
        if (cfg_q.tim_unlock) cfg_q.cl <= wdata_i[2:0];
        cfg_q.tim_unlock <= wdata_i[4];
        if (wdata_i[5]) begin
          cfg_q.boot_unlock <= 1'b1;
        end else if (cfg_q.boot_unlock) begin
          cfg_q.drive       <= wdata_i[3];
          cfg_q.boot_unlock <= 1'b0;
        end
      end
      if (be_i[1]) cfg_q.rows <= wdata_i[10:8];
      if (be_i[2]) cfg_q.misc <= wdata_i[23:16];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tim1_q <= TIM1_RST;
      tim2_q <= TIM2_RST;
    end else if (cfg_q.tim_unlock) begin
      for (int b = 0; b < NB; b++) begin
        if (wr_t1 && be_i[b]) tim1_q[8*b +: 8] <= wdata_i[8*b +: 8];
        if (wr_t2 && be_i[b]) tim2_q[8*b +: 8] <= wdata_i[8*b +: 8];
      end
    end
  end

  // refresh rate frozen while an init sequence is pending or running
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rfr_q <= RFR_RST;
    end else if (wr_rf && !busy_i) begin
      for (int b = 0; b < RFRB; b++) begin
        if (be_i[b]) rfr_q[8*b +: 8] <= wdata_i[8*b +: 8];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      AW'(0): begin
        rdata_o[2:0]   = cfg_q.cl;
        rdata_o[3]     = cfg_q.drive;
        rdata_o[4]     = cfg_q.tim_unlock;
        rdata_o[5]     = cfg_q.boot_unlock;
        rdata_o[10:8]  = cfg_q.rows;
        rdata_o[23:16] = cfg_q.misc;
      end
      AW'(1): rdata_o = tim1_q;
      AW'(2): rdata_o = tim2_q;
      default: rdata_o[RFR_W-1:0] = rfr_q;
    endcase
  end

  assign cfg_lo_wr_o = wr_cfg && (be_i[1:0] != 2'b00);
  assign cfg_o  = cfg_q;
  assign tim1_o = tim1_q;
  assign tim2_o = tim2_q;
  assign rfr_o  = rfr_q;
endmodule

// File: rtl/dic_trig.sv
module dic_trig (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic soft_rst_i,
  input  logic cfg_lo_wr_i,
  input  logic start_i,
  output logic pend_o
);
  logic pend_q;

  // hard reset leaves a request pending; new triggers win over the start clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b1;
    else         pend_q <= (pend_q && !start_i) || soft_rst_i || cfg_lo_wr_i;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/dic_seq.sv
module dic_seq
  import dic_pkg::*;
#(
  parameter int unsigned MW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          q_idle_i,
  input  logic          done_i,
  input  logic [2:0]    cl_i,
  input  logic          drive_i,
  output logic          active_o,
  output logic          cmd_valid_o,
  output logic [1:0]    cmd_op_o,
  output logic [1:0]    cmd_bank_o,
  output logic [MW-1:0] cmd_addr_o
);
  localparam int unsigned SW   = $clog2(NSTEPS);
  localparam logic [SW-1:0] LAST = SW'(NSTEPS - 1);

  typedef enum logic [1:0] {S_IDLE, S_DRAIN, S_CMD} st_e;

  st_e           st_q;
  logic [SW-1:0] step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      step_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE:  if (start_i) st_q <= S_DRAIN;
        S_DRAIN: if (q_idle_i) begin
          st_q   <= S_CMD;
          step_q <= '0;
        end
        default: if (done_i) begin
          if (step_q == LAST) st_q <= S_IDLE;
          else                step_q <= step_q + 1'b1;
        end
      endcase
    end
  end

  logic [MW-1:0] mr_w, emr1_w, pre_w;
  always_comb begin
    mr_w       = '0;
    mr_w[6:4]  = cl_i;
    emr1_w     = '0;
    emr1_w[1]  = drive_i;
    emr1_w[2]  = 1'b1;  // with bit 6 low: 75 ohm termination; bit 0 low: DLL on
    pre_w      = '0;
    pre_w[10]  = 1'b1;  // all banks
  end

  dram_op_e      op;
  logic [1:0]    bank;
  logic [MW-1:0] addr;
  always_comb begin
    op   = OP_MRS;
    bank = 2'd0;
    addr = '0;
    unique case (step_q)
      SW'(0): begin op = OP_PRE; addr = pre_w; end
      SW'(1): bank = 2'd2;
      SW'(2): bank = 2'd3;
      SW'(3): begin bank = 2'd1; addr = emr1_w; end
      SW'(4): begin addr = mr_w; addr[8] = 1'b1; end
      SW'(5): begin op = OP_PRE; addr = pre_w; end
      SW'(6), SW'(7): op = OP_REF;
      default: addr = mr_w;
    endcase
  end

  assign active_o    = (st_q != S_IDLE);
  assign cmd_valid_o = (st_q == S_CMD);
  assign cmd_op_o    = cmd_valid_o ? op : OP_NOP;
  assign cmd_bank_o  = cmd_valid_o ? bank : 2'd0;
  assign cmd_addr_o  = cmd_valid_o ? addr : '0;
endmodule

// File: rtl/dram_init_ctrl.sv
module dram_init_ctrl
  import dic_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned AW    = 2,
  parameter int unsigned RFR_W = 16,
  parameter int unsigned MW    = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            soft_rst_i,
  input  logic            reg_we_i,
  input  logic [AW-1:0]   reg_addr_i,
  input  logic [DW/8-1:0] reg_be_i,
  input  logic [DW-1:0]   reg_wdata_i,
  output logic [DW-1:0]   reg_rdata_o,
  input  logic            cmdq_idle_i,
  output logic            cmd_valid_o,
  output logic [1:0]      cmd_op_o,
  output logic [1:0]      cmd_bank_o,
  output logic [MW-1:0]   cmd_addr_o,
  input  logic            cmd_done_i,
  output logic            busy_o,
  output logic            irq_o,
  output logic            dma_evt_o
);
  cfg_t             cfg_q;
  logic [DW-1:0]    tim1_q, tim2_q;
  logic [RFR_W-1:0] rfr_q;
  logic             cfg_lo_wr, pend, active, start;

  assign start  = pend && !active;
  assign busy_o = pend || active;

  dic_regs #(.DW(DW), .AW(AW), .RFR_W(RFR_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .be_i        (reg_be_i),
    .wdata_i     (reg_wdata_i),
    .busy_i      (busy_o),
    .cfg_o       (cfg_q),
    .tim1_o      (tim1_q),
    .tim2_o      (tim2_q),
    .rfr_o       (rfr_q),
    .rdata_o     (reg_rdata_o),
    .cfg_lo_wr_o (cfg_lo_wr)
  );

  dic_trig u_trig (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .soft_rst_i  (soft_rst_i),
    .cfg_lo_wr_i (cfg_lo_wr),
    .start_i     (start),
    .pend_o      (pend)
  );

  dic_seq #(.MW(MW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .q_idle_i    (cmdq_idle_i),
    .done_i      (cmd_done_i),
    .cl_i        (cfg_q.cl),
    .drive_i     (cfg_q.drive),
    .active_o    (active),
    .cmd_valid_o (cmd_valid_o),
    .cmd_op_o    (cmd_op_o),
    .cmd_bank_o  (cmd_bank_o),
    .cmd_addr_o  (cmd_addr_o)
  );

  assign irq_o     = 1'b0;
  assign dma_evt_o = 1'b0;
endmodule

// File: rtl/dic_chk.sv
module dic_chk #(
  parameter int unsigned DW    = 32,
  parameter int unsigned RFR_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmdq_idle_i,
  input logic             cmd_valid_o,
  input logic             cmd_done_i,
  input logic [1:0]       cmd_op_o,
  input logic [1:0]       cmd_bank_o,
  input logic             busy_o,
  input logic             tim_unlock,
  input logic             boot_unlock,
  input logic             drive,
  input logic [DW-1:0]    tim1,
  input logic [DW-1:0]    tim2,
  input logic [RFR_W-1:0] rfr
);
  a_r4_drain_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_valid_o) |-> $past(cmdq_idle_i));

  a_r5_drive_guard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(drive) |-> $past(boot_unlock));

  a_r6_timing_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(tim_unlock) |-> ($stable(tim1) && $stable(tim2)));

  a_r7_cmd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_done_i) |=> (cmd_valid_o && $stable(cmd_op_o) && $stable(cmd_bank_o)));

  a_r9_valid_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> busy_o);

  a_r10_rfr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_o) |-> $stable(rfr));
endmodule

bind dram_init_ctrl dic_chk #(.DW(DW), .RFR_W(RFR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmdq_idle_i (cmdq_idle_i),
  .cmd_valid_o (cmd_valid_o),
  .cmd_done_i  (cmd_done_i),
  .cmd_op_o    (cmd_op_o),
  .cmd_bank_o  (cmd_bank_o),
  .busy_o      (busy_o),
  .tim_unlock  (cfg_q.tim_unlock),
  .boot_unlock (cfg_q.boot_unlock),
  .drive       (cfg_q.drive),
  .tim1        (tim1_q),
  .tim2        (tim2_q),
  .rfr         (rfr_q)
);

// File: tb/test_dram_init_ctrl.sv
`timescale 1ns/1ps
module test_dram_init_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        soft_rst_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = 2'd0;
  logic [3:0]  reg_be_i = 4'd0;
  logic [31:0] reg_wdata_i = 32'd0;
  logic [31:0] reg_rdata_o;
  logic        cmdq_idle_i = 1'b1;
  logic        cmd_valid_o;
  logic [1:0]  cmd_op_o, cmd_bank_o;
  logic [15:0] cmd_addr_o;
  logic        cmd_done_i = 1'b0;
  logic        busy_o, irq_o, dma_evt_o;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2.5 clk_i = ~clk_i;

  dram_init_ctrl i_dram_init_ctrl (.*);

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run did not finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_be_i = be; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0; reg_be_i = 4'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #0.1;
    d = reg_rdata_o;
  endtask

  task automatic side_chk(input string tag);
    check({irq_o, dma_evt_o} == 2'b00, {"R11 ", tag}, {30'd0, irq_o, dma_evt_o}, 32'd0);
  endtask

  // mid: 0 none, 1 config retrigger, 2 refresh write while busy
  task automatic run_seq(input logic [2:0] cl, input logic drv, input int mid, input string tag);
    logic [1:0]  eo, eb;
    logic [15:0] ea;
    logic [31:0] r;
    for (int i = 0; i < 9; i++) begin
      while (!cmd_valid_o) @(negedge clk_i);
      eo = 2'd3; eb = 2'd0; ea = 16'h0;
      case (i)
        0, 5: begin eo = 2'd1; ea = 16'h0400; end
        1: eb = 2'd2;
        2: eb = 2'd3;
        3: begin eb = 2'd1; ea = 16'h0004 | {14'd0, drv, 1'b0}; end
        4: ea = 16'h0100 | {9'd0, cl, 4'd0};
        6, 7: eo = 2'd2;
        default: ea = {9'd0, cl, 4'd0};
      endcase
      check({cmd_op_o, cmd_bank_o, cmd_addr_o} == {eo, eb, ea},
            $sformatf("R7 R8 %s step %0d", tag, i),
            {12'd0, cmd_op_o, cmd_bank_o, cmd_addr_o}, {12'd0, eo, eb, ea});
      if (i == 3 && mid == 1) wr(2'd0, 4'b0001, 32'h0000_000B);
      if (i == 3 && mid == 2) wr(2'd3, 4'b1111, 32'h0000_BEEF);
      if (i == 3) check(cmd_valid_o && busy_o, {"R7 R9 hold ", tag},
                        {30'd0, cmd_valid_o, busy_o}, 32'd3);
      cmd_done_i = 1'b1;
      @(negedge clk_i);
      cmd_done_i = 1'b0;
    end
    check(busy_o == (mid == 1), {"R9 busy after last done ", tag}, {31'd0, busy_o}, {31'd0, mid == 1});
    if (mid == 2) begin
      rd(2'd3, r);
      check(r == 32'h0000_0400, "R10 refresh write ignored while busy", r, 32'h0000_0400);
    end
    side_chk(tag);
  endtask

  // {addr[70:69], be[68:65], wdata[64:33], readback[32:1], trigger[0]}
  localparam logic [70:0] VEC [12] = '{
    {2'd3, 4'hF, 32'h0000_0400, 32'h0000_0400, 1'b0},
    {2'd1, 4'hF, 32'hAAAA_5555, 32'h2222_1111, 1'b0},
    {2'd0, 4'h4, 32'h0077_0000, 32'h0077_0205, 1'b0},
    {2'd0, 4'h1, 32'h0000_0003, 32'h0077_0205, 1'b1},
    {2'd0, 4'h1, 32'h0000_0028, 32'h0077_0225, 1'b1},
    {2'd0, 4'h1, 32'h0000_0008, 32'h0077_020D, 1'b1},
    {2'd0, 4'h1, 32'h0000_001B, 32'h0077_021D, 1'b1},
    {2'd1, 4'hF, 32'hAAAA_5555, 32'hAAAA_5555, 1'b0},
    {2'd2, 4'h3, 32'h0000_4444, 32'h0000_4444, 1'b0},
    {2'd0, 4'h3, 32'h0000_0303, 32'h0077_030B, 1'b1},
    {2'd1, 4'hF, 32'h0000_0000, 32'hAAAA_5555, 1'b0},
    {2'd0, 4'h8, 32'hFF00_0000, 32'h0077_030B, 1'b0}
  };

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    rd(2'd0, r); check(r == 32'h0000_0205, "R1 config default", r, 32'h0000_0205);
    rd(2'd1, r); check(r == 32'h2222_1111, "R1 timing1 default", r, 32'h2222_1111);
    rd(2'd2, r); check(r == 32'h0000_3333, "R1 timing2 default", r, 32'h0000_3333);
    rd(2'd3, r); check(r == 32'h0000_0618, "R1 refresh default", r, 32'h0000_0618);
    check(busy_o, "R1 busy after hard reset", {31'd0, busy_o}, 32'd1);
    side_chk("reset");
    run_seq(3'd5, 1'b0, 0, "R1 hard reset init");

    // register vectors: R3 R5 R6 R10
    for (int i = 0; i < 12; i++) begin
      wr(VEC[i][70:69], VEC[i][68:65], VEC[i][64:33]);
      rd(VEC[i][70:69], r);
      check(r == VEC[i][32:1], $sformatf("R3 R5 R6 R10 vector %0d readback", i), r, VEC[i][32:1]);
      check(busy_o == VEC[i][0], $sformatf("R3 vector %0d trigger", i), {31'd0, busy_o}, {31'd0, VEC[i][0]});
      if (VEC[i][0]) begin
        rd(2'd0, r);
        run_seq(r[2:0], r[3], 0, $sformatf("vector %0d", i));
      end
    end

    // R4 deferred start while queue busy
    cmdq_idle_i = 1'b0;
    wr(2'd0, 4'b0001, 32'h0000_000B);
    for (int k = 0; k < 10; k++) begin
      check(!cmd_valid_o && busy_o, "R4 no command while queue busy",
            {30'd0, cmd_valid_o, busy_o}, 32'd1);
      @(negedge clk_i);
    end
    cmdq_idle_i = 1'b1;
    run_seq(3'd3, 1'b1, 0, "R4 after drain");

    // R9 latched retrigger
    wr(2'd0, 4'b0010, 32'h0000_0300);
    run_seq(3'd3, 1'b1, 1, "R9 first");
    run_seq(3'd3, 1'b1, 0, "R9 rerun");

    // R10 refresh write while busy
    wr(2'd0, 4'b0001, 32'h0000_000B);
    run_seq(3'd3, 1'b1, 2, "R10");

    // R2 soft reset keeps registers
    @(negedge clk_i);
    soft_rst_i = 1'b1;
    @(negedge clk_i);
    soft_rst_i = 1'b0;
    check(busy_o, "R2 busy after soft reset", {31'd0, busy_o}, 32'd1);
    rd(2'd0, r); check(r == 32'h0077_030B, "R2 config kept", r, 32'h0077_030B);
    rd(2'd1, r); check(r == 32'hAAAA_5555, "R2 timing1 kept", r, 32'hAAAA_5555);
    rd(2'd3, r); check(r == 32'h0000_0400, "R2 refresh kept", r, 32'h0000_0400);
    run_seq(3'd3, 1'b1, 0, "R2 soft reset init");

    // R1 hard reset reloads defaults
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    rd(2'd0, r); check(r == 32'h0000_0205, "R1 config reloaded", r, 32'h0000_0205);
    rd(2'd1, r); check(r == 32'h2222_1111, "R1 timing1 reloaded", r, 32'h2222_1111);
    rd(2'd2, r); check(r == 32'h0000_3333, "R1 timing2 reloaded", r, 32'h0000_3333);
    rd(2'd3, r); check(r == 32'h0000_0618, "R1 refresh reloaded", r, 32'h0000_0618);
    run_seq(3'd5, 1'b0, 0, "R1 second hard reset");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule